// File: doc/BRIEF.md
# Watchdog Reset Gate with Cause Latch

This block sits beside a watchdog timer on the power-management side of a chip. It decides whether a reset request from the watchdog is passed on to the system, and whether the watchdog's counter is allowed to run. It also records that the last reset came from the watchdog, in a flag that outlives the system reset the block itself causes.

Software reaches four small registers over a simple write-strobe and combinational read bus. Each register holds a single meaningful bit, and that bit's position is a parameter:

- a reset-block register;
- an automatic-suppression register, which blocks the reset while the associated processor is held in reset;
- a counter-run register;
- a cause register, which is cleared by writing one to it.

A parameter picks the polarity of the reset-block bit. In blocking style, 1 blocks the reset. In permit style, 1 lets it through.

Two resets are used. `por_n` is the power-on reset and clears everything. `sys_rst_n` is the system reset and returns the control bits to their safe state, but leaves the cause flag alone.

Top module: `wdt_rst_gate`

## Requirements
- R1: After power-on reset the block is in its safe state. The reset is blocked: the reset-block bit reads 1 in blocking style and 0 in permit style. The counter-run bit, the suppression bit and the cause flag all read 0, and both outputs are low.
- R2: The output `cnt_run` equals the counter-run bit, which is bit 7 of address 2 by default. It changes on the clock edge that performs the write.
- R3: In blocking style (`BLOCK_INV`=0), a 1 in the reset-block bit (bit 2 of address 0 by default) keeps `rst_out` low whatever the request does.
- R4: In permit style (`BLOCK_INV`=1), the same bit passes the request when it is 1 and blocks it when it is 0.
- R5: While the suppression bit (bit 2 of address 1 by default) is 1 and `cpu_in_rst` is high, `rst_out` stays low.
- R6: `rst_out` is the request, qualified by the blocking and suppression rules, delayed by exactly one register. It is high in the cycle after a qualifying `wdt_req` and low in the cycle after the request drops.
- R7: The cause flag (bit 0 of address 3 by default) is set on the edge where `rst_out` rises. It is not cleared by `sys_rst_n`.
- R8: Writing 1 to the cause flag's bit position clears it, and writing 0 leaves it unchanged. If a set and a clear land on the same edge, the set wins.
- R9: Only `por_n` clears the cause flag.
- R10: Register bits other than the configured one read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; resets control bits only |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 block, 1 suppress, 2 counter run, 3 cause) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| wdt_req | input | 1 | Reset request from the watchdog |
| cpu_in_rst | input | 1 | Associated processor is held in reset |
| rst_out | output | 1 | Gated system reset request, registered |
| cnt_run | output | 1 | Watchdog counter may run |

## Verification
Some properties are checked by assertions on every cycle:

- a rise of `rst_out` always follows a request;
- `rst_out` never appears one cycle after a suppressed request;
- whenever `rst_out` is high the cause flag is set;
- the cause flag falls only after a one-write to it;
- `cnt_run` rises only after a write to its register.

Other behaviour can only be shown by the bench's scenarios. These are the sweep of every combination of blocking bit, suppression bit, processor state and request in both polarities, the survival of the cause flag across a system reset, the precedence of set over clear, and the read-back of unused bits as zero.

// File: rtl/wdt_rst_gate.sv
module wdt_rst_gate #(
  parameter int DW        = 8,
  parameter bit BLOCK_INV = 1'b0,
  parameter int BLOCK_BIT = 2,
  parameter int SUPP_BIT  = 2,
  parameter int RUN_BIT   = 7,
  parameter int CAUSE_BIT = 0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wdt_req,
  input  logic          cpu_in_rst,
  output logic          rst_out,
  output logic          cnt_run
);
  localparam logic [1:0] A_BLOCK = 2'd0;
  localparam logic [1:0] A_SUPP  = 2'd1;
  localparam logic [1:0] A_RUN   = 2'd2;
  localparam logic [1:0] A_CAUSE = 2'd3;
  localparam logic       BLOCK_SAFE = ~BLOCK_INV;

  logic ctl_rst_n;
  logic block_q, supp_q, run_q, cause_q, gate_q;
  logic blocked, suppressed, gate_d;
  logic wr_block, wr_supp, wr_run, clr_cause;

  assign ctl_rst_n  = por_n & sys_rst_n;
  assign wr_block   = bus_we && bus_addr == A_BLOCK;
  assign wr_supp    = bus_we && bus_addr == A_SUPP;
  assign wr_run     = bus_we && bus_addr == A_RUN;
  assign clr_cause  = bus_we && bus_addr == A_CAUSE && bus_wdata[CAUSE_BIT];

  assign blocked    = block_q ^ BLOCK_INV;
  assign suppressed = supp_q & cpu_in_rst;
  assign gate_d     = wdt_req & ~blocked & ~suppressed;

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      block_q <= BLOCK_SAFE;
      supp_q  <= 1'b0;
      run_q   <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      if (wr_block) block_q <= bus_wdata[BLOCK_BIT];
      if (wr_supp)  supp_q  <= bus_wdata[SUPP_BIT];
      if (wr_run)   run_q   <= bus_wdata[RUN_BIT];
      gate_q <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     cause_q <= 1'b0;
    else if (gate_d && ctl_rst_n)   cause_q <= 1'b1;
    else if (clr_cause)             cause_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_BLOCK: bus_rdata[BLOCK_BIT] = block_q;
      A_SUPP:  bus_rdata[SUPP_BIT]  = supp_q;
      A_RUN:   bus_rdata[RUN_BIT]   = run_q;
      default: bus_rdata[CAUSE_BIT] = cause_q;
    endcase
  end

  assign rst_out = gate_q;
  assign cnt_run = run_q;

  assert_req_precedes_rst_R6: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $rose(rst_out) |-> $past(wdt_req));
  assert_supp_blocks_R5: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $past(supp_q && cpu_in_rst) |-> !rst_out);
  assert_cause_with_rst_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_out |-> cause_q);
  assert_cause_w1c_R8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cause_q) |-> $past(bus_we && bus_addr == A_CAUSE && bus_wdata[CAUSE_BIT]));
  assert_run_needs_write_R2: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $rose(cnt_run) |-> $past(bus_we && bus_addr == A_RUN));
endmodule

// File: tb/sim_wdt_rst_gate.sv
`timescale 1ns/1ps
module sim_wdt_rst_gate;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic wdt_req = 1'b0, cpu_in_rst = 1'b0;
  logic [7:0] rd0, rd1;
  logic rst0, rst1, run0, run1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_rst_gate #(.BLOCK_INV(1'b0)) u0 (.clk, .por_n, .sys_rst_n, .bus_we, .bus_addr,
    .bus_wdata, .bus_rdata(rd0), .wdt_req, .cpu_in_rst, .rst_out(rst0), .cnt_run(run0));
  wdt_rst_gate #(.BLOCK_INV(1'b1)) u1 (.clk, .por_n, .sys_rst_n, .bus_we, .bus_addr,
    .bus_wdata, .bus_rdata(rd1), .wdt_req, .cpu_in_rst, .rst_out(rst1), .cnt_run(run1));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v0, output logic [7:0] v1);
    bus_addr = a; #1; v0 = rd0; v1 = rd1;
  endtask

  initial begin
    logic [7:0] a0, a1;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, a0, a1); chk("R1 block u0", a0, 8'h04); chk("R1 block u1", a1, 8'h00);
    rd(2'd1, a0, a1); chk("R1 supp", a0, 8'h00);
    rd(2'd2, a0, a1); chk("R1 run", a0, 8'h00);
    rd(2'd3, a0, a1); chk("R1 cause", a0, 8'h00);
    chk("R1 outputs", {4'b0, rst0, rst1, run0, run1}, 8'h00);
    // R2 / R10 counter run
    wr(2'd2, 8'hFF); chk("R2 run on", {7'b0, run0}, 8'h01);
    rd(2'd2, a0, a1); chk("R10 run readback", a0, 8'h80);
    wr(2'd2, 8'h7F); chk("R2 run off", {7'b0, run0}, 8'h00);
    wr(2'd0, 8'hFB); rd(2'd0, a0, a1); chk("R10 unused bits", a0, 8'h00);
    // R3 R4 R5 R6 sweep
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++) begin
        wr(2'd0, 8'(m << 2));
        wr(2'd1, 8'(s << 2));
        for (int c = 0; c < 2; c++)
          for (int r = 0; r < 2; r++) begin
            cpu_in_rst = c[0]; wdt_req = r[0];
            @(negedge clk);
            chk("R3 R5 R6 block-style", {7'b0, rst0},
                {7'b0, r[0] & ~m[0] & ~(s[0] & c[0])});
            chk("R4 R5 R6 permit-style", {7'b0, rst1},
                {7'b0, r[0] & m[0] & ~(s[0] & c[0])});
            wdt_req = 1'b0; @(negedge clk);
            chk("R6 drop", {6'b0, rst0, rst1}, 8'h00);
          end
      end
    cpu_in_rst = 1'b0;
    wr(2'd1, 8'h00);
    // R7 R8 R9 cause flag
    wr(2'd3, 8'h01); rd(2'd3, a0, a1); chk("R8 clear", a0, 8'h00);
    wr(2'd0, 8'h00);
    wdt_req = 1'b1; @(negedge clk); wdt_req = 1'b0;
    chk("R6 pulse", {7'b0, rst0}, 8'h01);
    rd(2'd3, a0, a1); chk("R7 set", a0, 8'h01); chk("R7 u1 blocked", a1, 8'h00);
    sys_rst_n = 1'b0; #1;
    chk("R7 out in sys reset", {7'b0, rst0}, 8'h00);
    @(negedge clk); sys_rst_n = 1'b1; @(negedge clk);
    rd(2'd3, a0, a1); chk("R7 survives sys reset", a0, 8'h01);
    rd(2'd0, a0, a1); chk("R1 block after sys reset", a0, 8'h04);
    wr(2'd3, 8'hFE); rd(2'd3, a0, a1); chk("R8 write 0 keeps", a0, 8'h01);
    wr(2'd3, 8'h01); rd(2'd3, a0, a1); chk("R8 w1c", a0, 8'h00);
    wr(2'd0, 8'h00);
    @(negedge clk); bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h01; wdt_req = 1'b1;
    @(negedge clk); bus_we = 1'b0; wdt_req = 1'b0;
    rd(2'd3, a0, a1); chk("R8 set wins", a0, 8'h01);
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    rd(2'd3, a0, a1); chk("R9 por clears", a0, 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule